// File: doc/BRIEF.md
# Single-Wire Debug Command Sequencer

This block drives the host end of a one-wire background debug link. A local controller hands it one request at a time: a hardware-level read or write, a firmware-level read or write, a single-step, or a resume. The sequencer serializes the command byte, then the address and data words the command needs, onto an open-drain data line that idles high. It inserts the minimum pause, counted in target bus cycles, that each command class requires before read data is clocked in or before the link may carry another command. For reads it times the returned bits, samples them and presents the assembled word.

Every bit occupies a slot of 16 target serial cycles. The host starts each slot by pulling the line low. A transmitted one is a short low pulse and a zero is a long one. A read slot is started with a short pulse and then sampled mid-slot while the target may hold the line low. Serial and bus cycle lengths come from two divide inputs, so one build serves any target clock rate.

Controller states: `S_IDLE` (waiting; accepts a request with a legal kind → `S_OPCODE`), `S_OPCODE` (command byte; after its last bit → `S_ADDR` for hardware kinds, `S_GAP_RD` for firmware read, `S_WDATA` for firmware write, `S_GAP_END` for step/resume), `S_ADDR` (address word; → `S_GAP_RD` for hardware read, `S_WDATA` for hardware write), `S_WDATA` (write data; → `S_GAP_END`), `S_GAP_RD` (pause before read data; on expiry → `S_RDATA`), `S_RDATA` (read slots; after the last → `S_IDLE` with the result), `S_GAP_END` (closing pause; on expiry → `S_IDLE`).

Top module: `dbg_link_seq`

## Requirements
- R1: Every bit slot lasts 16 serial cycles and begins with the line driven low (`line_oe`=1). Between slots and while idle the line is released, so consecutive slot starts are 16 serial cycles plus a short released interval apart.
- R2: A transmitted 1 holds the line low for exactly 4 serial cycles and a 0 for exactly 13; each field is sent most significant bit first.
- R3: The command byte is {1, kind[2:0], wide, 3'b100}, with kind 0 = hardware read, 1 = hardware write, 2 = firmware read, 3 = firmware write, 4 = single-step, 5 = resume.
- R4: A hardware read sends the command byte and the 16-bit address, pauses at least 150 bus cycles after the last address slot, then runs 16 (wide) or 8 (byte) read slots and presents the word on `rd_data` with a one-clock `rd_valid`.
- R5: A hardware write sends the command byte, the 16-bit address and the data (all 16 bits when wide, else the low 8 bits), then keeps `busy` high for at least 150 bus cycles after the last data slot.
- R6: A firmware read sends only the command byte, pauses at least 48 bus cycles, then runs the read slots as in R4.
- R7: A firmware write sends the command byte and the data, then keeps `busy` high for at least 36 bus cycles after the last data slot.
- R8: Single-step and resume send only the command byte, then keep `busy` high for at least 76 bus cycles.
- R9: On a wide access the transmitted address has bit 0 forced to 0; a byte access sends the address unchanged.
- R10: A read slot drives the line low for 4 serial cycles, then samples the line in serial cycle 10 (low reads as 0); bits fill the result most significant first, and a byte read returns the value zero-extended in `rd_data[7:0]`.
- R11: `busy` rises on the clock after an accepted request and falls when the closing pause expires or the last read slot ends; requests while busy and requests with kind 6 or 7 are ignored.
- R12: A serial cycle lasts `serial_div`+1 local clocks and a bus cycle `bus_div`+1 local clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_div | input | DIV_W | Local clocks per serial cycle, minus one |
| bus_div | input | DIV_W | Local clocks per target bus cycle, minus one |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_kind | input | 3 | Command kind (encoding in R3) |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | WORD_W | Target address for hardware kinds |
| req_wdata | input | WORD_W | Write data |
| busy | output | 1 | Command in progress |
| rd_valid | output | 1 | One-clock pulse when `rd_data` is updated |
| rd_data | output | WORD_W | Last read result |
| line_oe | output | 1 | 1 = pull the data line low |
| line_in | input | 1 | Observed level of the data line |

## Verification
The hardest situation to reach is a read slot in which the returned bit depends on the target pulling the line low past the host's own short pulse and through the sample point, while the pause before it must also be measured against the bus divide. The bench models the target on the wire: when it sees the host open a slot it knows to be a read slot, it holds the line low for twelve serial cycles for each zero bit of a chosen word. It then checks the assembled word and the measured pause. Random divides, kinds, widths and odd addresses run alongside directed all-zero and all-one data and requests fired repeatedly while busy.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

    typedef enum logic [2:0] {
        K_HW_RD  = 3'd0,
        K_HW_WR  = 3'd1,
        K_FW_RD  = 3'd2,
        K_FW_WR  = 3'd3,
        K_STEP   = 3'd4,
        K_RESUME = 3'd5
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR,
        S_WDATA,
        S_GAP_RD,
        S_RDATA,
        S_GAP_END
    } seq_state_e;

    function automatic logic kind_ok(input logic [2:0] k);
        return k <= 3'd5;
    endfunction

    function automatic logic [7:0] opcode_of(input logic [2:0] k, input logic w);
        return {1'b1, k, w, 3'b100};
    endfunction

endpackage

// File: rtl/tick_div.sv
module tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || cnt_q == div)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == div) && !restart;
endmodule

// File: rtl/slot_engine.sv
module slot_engine #(
    parameter int SLOT_LEN  = 16,
    parameter int ONE_LOW   = 4,
    parameter int ZERO_LOW  = 13,
    parameter int RD_LOW    = 4,
    parameter int SAMPLE_AT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tx_bit,
    input  logic rd_mode,
    input  logic ser_tick,
    input  logic line_in,
    output logic line_oe,
    output logic done,
    output logic rx_bit
);
    localparam int SC_W = $clog2(SLOT_LEN);
    localparam logic [SC_W-1:0] LAST_SC  = SC_W'(SLOT_LEN - 1);
    localparam logic [SC_W-1:0] SAMP_SC  = SC_W'(SAMPLE_AT);
    localparam logic [SC_W-1:0] ONE_SC   = SC_W'(ONE_LOW);
    localparam logic [SC_W-1:0] ZERO_SC  = SC_W'(ZERO_LOW);
    localparam logic [SC_W-1:0] RDLO_SC  = SC_W'(RD_LOW);

    logic            active_q;
    logic [SC_W-1:0] sc_q;
    logic            bit_q;
    logic            rd_q;
    logic [1:0]      sync_q;
    logic [SC_W-1:0] low_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], line_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sc_q     <= '0;
            bit_q    <= 1'b0;
            rd_q     <= 1'b0;
            done     <= 1'b0;
            rx_bit   <= 1'b1;
        end else begin
            done <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                sc_q     <= '0;
                bit_q    <= tx_bit;
                rd_q     <= rd_mode;
            end else if (active_q && ser_tick) begin
                if (sc_q == SAMP_SC)
                    rx_bit <= sync_q[1];
                if (sc_q == LAST_SC) begin
                    active_q <= 1'b0;
                    done     <= 1'b1;
                end else begin
                    sc_q <= sc_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (rd_q)
            low_len = RDLO_SC;
        else if (bit_q)
            low_len = ONE_SC;
        else
            low_len = ZERO_SC;
    end

    assign line_oe = active_q && (sc_q < low_len);
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             bus_tick,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                cnt_q <= load_val;
            end else if (bus_tick && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1))
                    done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbg_link_seq.sv
module dbg_link_seq
    import dbg_link_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int WORD_W    = 16,
    parameter int SLOT_LEN  = 16,
    parameter int ONE_LOW   = 4,
    parameter int ZERO_LOW  = 13,
    parameter int RD_LOW    = 4,
    parameter int SAMPLE_AT = 10,
    parameter int HW_GAP    = 150,
    parameter int FW_RD_GAP = 48,
    parameter int FW_WR_GAP = 36,
    parameter int RUN_GAP   = 76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  serial_div,
    input  logic [DIV_W-1:0]  bus_div,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic              req_wide,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              line_oe,
    input  logic              line_in
);
    localparam int BYTE_W  = WORD_W / 2;
    localparam int CNT_W   = $clog2(WORD_W);
    localparam int GAP_M1  = (HW_GAP > FW_RD_GAP) ? HW_GAP : FW_RD_GAP;
    localparam int GAP_M2  = (FW_WR_GAP > RUN_GAP) ? FW_WR_GAP : RUN_GAP;
    localparam int GAP_MAX = (GAP_M1 > GAP_M2) ? GAP_M1 : GAP_M2;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    seq_state_e        state_q, state_d;
    cmd_kind_e         kind_q;
    logic              wide_q;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] tx_sr_q;
    logic [WORD_W-1:0] rx_sr_q;
    logic [CNT_W-1:0]  bits_left_q;
    logic              kick_q;
    logic              wait_go_q;
    logic [GAP_W-1:0]  wait_val_q;
    logic              rd_valid_q;
    logic [WORD_W-1:0] rd_data_q;

    logic              accept;
    logic              last_bit;
    logic              slot_done;
    logic              slot_rx;
    logic              wait_done;
    logic [WORD_W-1:0] rx_next;
    logic [CNT_W-1:0]  word_bits;
    logic [GAP_W-1:0]  gap_rd_val;
    logic [GAP_W-1:0]  gap_end_val;

    // two prescalers: index 0 serial cycle, index 1 bus cycle
    logic [DIV_W-1:0]  pdiv [2];
    logic [1:0]        prst;
    logic [1:0]        ptick;

    assign pdiv[0] = serial_div;
    assign pdiv[1] = bus_div;
    assign prst    = {wait_go_q, kick_q};

    for (genvar g = 0; g < 2; g++) begin : g_pre
        tick_div #(.W(DIV_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (prst[g]),
            .div     (pdiv[g]),
            .tick    (ptick[g])
        );
    end

    slot_engine #(
        .SLOT_LEN  (SLOT_LEN),
        .ONE_LOW   (ONE_LOW),
        .ZERO_LOW  (ZERO_LOW),
        .RD_LOW    (RD_LOW),
        .SAMPLE_AT (SAMPLE_AT)
    ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (kick_q),
        .tx_bit   (tx_sr_q[WORD_W-1]),
        .rd_mode  (state_q == S_RDATA),
        .ser_tick (ptick[0]),
        .line_in  (line_in),
        .line_oe  (line_oe),
        .done     (slot_done),
        .rx_bit   (slot_rx)
    );

    wait_timer #(.CNT_W(GAP_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_go_q),
        .load_val (wait_val_q),
        .bus_tick (ptick[1]),
        .done     (wait_done)
    );

    assign accept    = req_valid && kind_ok(req_kind);
    assign last_bit  = (bits_left_q == '0);
    assign rx_next   = {rx_sr_q[WORD_W-2:0], slot_rx};
    assign word_bits = wide_q ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);

    always_comb begin
        gap_rd_val  = (kind_q == K_HW_RD) ? GAP_W'(HW_GAP) : GAP_W'(FW_RD_GAP);
        unique case (kind_q)
            K_HW_WR: gap_end_val = GAP_W'(HW_GAP);
            K_FW_WR: gap_end_val = GAP_W'(FW_WR_GAP);
            default: gap_end_val = GAP_W'(RUN_GAP);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept)
                    state_d = S_OPCODE;
            end
            S_OPCODE: begin
                if (slot_done && last_bit) begin
                    unique case (kind_q)
                        K_HW_RD, K_HW_WR: state_d = S_ADDR;
                        K_FW_RD:          state_d = S_GAP_RD;
                        K_FW_WR:          state_d = S_WDATA;
                        default:          state_d = S_GAP_END;
                    endcase
                end
            end
            S_ADDR: begin
                if (slot_done && last_bit)
                    state_d = (kind_q == K_HW_RD) ? S_GAP_RD : S_WDATA;
            end
            S_WDATA: begin
                if (slot_done && last_bit)
                    state_d = S_GAP_END;
            end
            S_GAP_RD: begin
                if (wait_done)
                    state_d = S_RDATA;
            end
            S_RDATA: begin
                if (slot_done && last_bit)
                    state_d = S_IDLE;
            end
            S_GAP_END: begin
                if (wait_done)
                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // datapath: loads on state entry, shifts between slots
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q      <= K_HW_RD;
            wide_q      <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            tx_sr_q     <= '0;
            rx_sr_q     <= '0;
            bits_left_q <= '0;
            kick_q      <= 1'b0;
            wait_go_q   <= 1'b0;
            wait_val_q  <= '0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
        end else begin
            kick_q     <= 1'b0;
            wait_go_q  <= 1'b0;
            rd_valid_q <= 1'b0;
            if (state_q == S_RDATA && slot_done)
                rx_sr_q <= rx_next;
            if (state_d != state_q) begin
                case (state_d)
                    S_OPCODE: begin
                        kind_q      <= cmd_kind_e'(req_kind);
                        wide_q      <= req_wide;
                        addr_q      <= req_wide ? {req_addr[WORD_W-1:1], 1'b0} : req_addr;
                        wdata_q     <= req_wdata;
                        tx_sr_q     <= {opcode_of(req_kind, req_wide), {(WORD_W-8){1'b0}}};
                        bits_left_q <= CNT_W'(7);
                        kick_q      <= 1'b1;
                    end
                    S_ADDR: begin
                        tx_sr_q     <= addr_q;
                        bits_left_q <= CNT_W'(WORD_W - 1);
                        kick_q      <= 1'b1;
                    end
                    S_WDATA: begin
                        tx_sr_q     <= wide_q ? wdata_q
                                              : {wdata_q[BYTE_W-1:0], {BYTE_W{1'b0}}};
                        bits_left_q <= word_bits;
                        kick_q      <= 1'b1;
                    end
                    S_GAP_RD: begin
                        wait_val_q <= gap_rd_val;
                        wait_go_q  <= 1'b1;
                    end
                    S_GAP_END: begin
                        wait_val_q <= gap_end_val;
                        wait_go_q  <= 1'b1;
                    end
                    S_RDATA: begin
                        rx_sr_q     <= '0;
                        bits_left_q <= word_bits;
                        kick_q      <= 1'b1;
                    end
                    S_IDLE: begin
                        if (state_q == S_RDATA) begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= wide_q ? rx_next
                                                 : {{BYTE_W{1'b0}}, rx_next[BYTE_W-1:0]};
                        end
                    end
                    default: ;
                endcase
            end else if (slot_done && !last_bit) begin
                tx_sr_q     <= {tx_sr_q[WORD_W-2:0], 1'b0};
                bits_left_q <= bits_left_q - 1'b1;
                kick_q      <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        rd_valid = rd_valid_q;
        rd_data  = rd_data_q;
    end
endmodule

// File: rtl/dbg_link_seq_chk.sv
module dbg_link_seq_chk #(
    parameter int DIV_W  = 8,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIV_W-1:0]  serial_div,
    input logic              req_valid,
    input logic [2:0]        req_kind,
    input logic              req_wide,
    input logic              busy,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic              line_oe
);
    localparam int BYTE_W = WORD_W / 2;

    logic [31:0] low_cnt;
    logic        wide_seen;
    logic [31:0] unit;

    assign unit = 32'(serial_div) + 32'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt   <= '0;
            wide_seen <= 1'b0;
        end else begin
            low_cnt <= line_oe ? low_cnt + 32'd1 : 32'd0;
            if (req_valid && !busy && req_kind <= 3'd5)
                wide_seen <= req_wide;
        end
    end

    // R1: line released whenever no command runs
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe);

    // R2: every low pulse is a short or long bit pulse
    p_low_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> (low_cnt == 32'd4 * unit || low_cnt == 32'd13 * unit));

    // R11: busy only starts after a legal request
    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_kind <= 3'd5));

    // R11: result appears as the sequencer goes idle
    p_rd_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

    // R10: byte reads are zero-extended
    p_zero_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !wide_seen) |-> (rd_data[WORD_W-1:BYTE_W] == '0));
endmodule

bind dbg_link_seq dbg_link_seq_chk #(.DIV_W(DIV_W), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .serial_div (serial_div),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_wide   (req_wide),
    .busy       (busy),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .line_oe    (line_oe)
);

// File: tb/test_dbg_link_seq.sv
module test_dbg_link_seq;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  serial_div = 8'd0;
    logic [7:0]  bus_div = 8'd0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic        req_wide = 1'b0;
    logic [15:0] req_addr = 16'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        busy;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        line_oe;
    logic        line_in;
    logic        pull = 1'b0;

    always #2.5 clk = ~clk;
    assign line_in = !(line_oe || pull);

    dbg_link_seq i_dbg_link_seq (
        .clk (clk), .rst_n (rst_n), .serial_div (serial_div), .bus_div (bus_div),
        .req_valid (req_valid), .req_kind (req_kind), .req_wide (req_wide),
        .req_addr (req_addr), .req_wdata (req_wdata), .busy (busy),
        .rd_valid (rd_valid), .rd_data (rd_data), .line_oe (line_oe), .line_in (line_in)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // wire monitor and target model
    int          ns = 0;
    int          st [64];
    int          ln [64];
    int          rd_first = 64;
    int          nrd_m = 0;
    logic [15:0] tgt = 16'd0;
    int          pull_left = 0;
    logic        got_rv = 1'b0;
    logic [15:0] got_rd = 16'd0;
    int          busy_fall = -1;
    logic        prev_oe = 1'b0;
    logic        prev_busy = 1'b0;

    always @(negedge clk) begin
        if (pull_left > 0) begin
            pull_left = pull_left - 1;
            if (pull_left == 0) pull = 1'b0;
        end
        if (line_oe && !prev_oe && ns < 64) begin
            st[ns] = cyc;
            if (ns >= rd_first && ns < rd_first + nrd_m) begin
                pull = !tgt[nrd_m - 1 - (ns - rd_first)];
                pull_left = 12 * (int'(serial_div) + 1);
            end
        end
        if (!line_oe && prev_oe && ns < 64) begin
            ln[ns] = cyc - st[ns];
            ns = ns + 1;
        end
        if (rd_valid) begin
            got_rv = 1'b1;
            got_rd = rd_data;
        end
        if (!busy && prev_busy) busy_fall = cyc;
        prev_oe   = line_oe;
        prev_busy = busy;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_opcode(input int kind, input bit wide);
        return {1'b1, 3'(kind), wide, 3'b100};
    endfunction

    function automatic int exp_ntx(input int kind, input bit wide);
        int dn = wide ? 16 : 8;
        case (kind)
            0: return 24;
            1: return 24 + dn;
            3: return 8 + dn;
            default: return 8;
        endcase
    endfunction

    function automatic longint exp_stream(input int kind, input bit wide,
                                          input logic [15:0] addr, input logic [15:0] wd);
        longint v = longint'(exp_opcode(kind, wide));
        logic [15:0] ea = wide ? {addr[15:1], 1'b0} : addr;
        if (kind <= 1) v = (v << 16) | longint'(ea);
        if (kind == 1 || kind == 3) begin
            if (wide) v = (v << 16) | longint'(wd);
            else      v = (v << 8) | longint'(wd[7:0]);
        end
        return v;
    endfunction

    function automatic int exp_gap(input int kind);
        case (kind)
            0, 1: return 150;
            2:    return 48;
            3:    return 36;
            default: return 76;
        endcase
    endfunction

    task automatic run_cmd(input int kind, input bit wide, input logic [15:0] addr,
                           input logic [15:0] wd, input logic [15:0] tv, input bit spam);
        int ntx = exp_ntx(kind, wide);
        int nrd = (kind == 0 || kind == 2) ? (wide ? 16 : 8) : 0;
        longint ev = exp_stream(kind, wide, addr, wd);
        int su = int'(serial_div) + 1;
        int bu = int'(bus_div) + 1;
        int gmin = exp_gap(kind) * bu;
        longint cap = 0;
        int bad_len = 0;
        int bad_sp = 0;
        int bad_rd = 0;
        string gtag;
        ns = 0; rd_first = ntx; nrd_m = nrd; tgt = tv; got_rv = 1'b0; busy_fall = -1;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'(kind); req_wide = wide;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        check(busy == 1'b1, "R11 busy after accept", longint'(busy), 1);
        if (spam) begin
            req_kind = 3'((kind + 1) % 6); req_wide = !wide; req_addr = ~addr; req_wdata = ~wd;
            repeat (30) @(negedge clk);
        end
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);

        check(ns == ntx + nrd, "R11 slot count (requests while busy ignored)",
              longint'(ns), longint'(ntx + nrd));
        if (ns == ntx + nrd) begin
            for (int i = 0; i < ntx; i++) begin
                cap = (cap << 1) | longint'(ln[i] < 8 * su);
                if (ln[i] != 4 * su && ln[i] != 13 * su) bad_len++;
            end
            check(bad_len == 0, "R2 low pulse length", longint'(bad_len), 0);
            check(cap == ev, (kind <= 1) ? "R3 R4 R5 stream" : "R3 R6 R7 R8 stream", cap, ev);
            if (kind <= 1)
                check(((cap >> (ntx - 24)) & 64'hFFFF) == longint'(wide ? {addr[15:1], 1'b0} : addr),
                      "R9 address", (cap >> (ntx - 24)) & 64'hFFFF,
                      longint'(wide ? {addr[15:1], 1'b0} : addr));
            for (int i = 1; i < ns; i++) begin
                if (i != ntx) begin
                    int d = st[i] - st[i-1];
                    if (d < 16 * su + 1 || d > 16 * su + 4) bad_sp++;
                end
            end
            check(bad_sp == 0, "R1 R12 slot spacing", longint'(bad_sp), 0);
            if (nrd > 0) begin
                int g = st[ntx] - (st[ntx-1] + 16 * su);
                logic [15:0] er = wide ? tv : {8'h00, tv[7:0]};
                for (int i = ntx; i < ns; i++) if (ln[i] != 4 * su) bad_rd++;
                check(bad_rd == 0, "R10 read slot pulse", longint'(bad_rd), 0);
                gtag = (kind == 0) ? "R4 pre-read gap" : "R6 pre-read gap";
                check(g >= gmin && g <= gmin + 8, gtag, longint'(g), longint'(gmin));
                check(got_rv == 1'b1, "R10 rd_valid seen", longint'(got_rv), 1);
                check(got_rd == er, "R10 read data", longint'(got_rd), longint'(er));
            end else begin
                int g = busy_fall - (st[ntx-1] + 16 * su);
                case (kind)
                    1: gtag = "R5 closing gap";
                    3: gtag = "R7 closing gap";
                    default: gtag = "R8 closing gap";
                endcase
                check(g >= gmin && g <= gmin + 8, gtag, longint'(g), longint'(gmin));
                check(got_rv == 1'b0, "R11 no rd_valid on non-read", longint'(got_rv), 0);
            end
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R11 reset busy", longint'(busy), 0);
        check(line_oe == 1'b0, "R1 reset line released", longint'(line_oe), 0);
        check(rd_valid == 1'b0, "R10 reset rd_valid", longint'(rd_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // undefined kinds are ignored
        req_valid = 1'b1; req_kind = 3'd6;
        @(negedge clk);
        req_kind = 3'd7;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && ns == 0, "R11 undefined kind ignored", longint'(busy), 0);

        // directed corners
        serial_div = 8'd0; bus_div = 8'd0;
        run_cmd(0, 1'b1, 16'h1235, 16'h0000, 16'h8001, 1'b0);
        serial_div = 8'd2; bus_div = 8'd1;
        run_cmd(3, 1'b0, 16'h0000, 16'hA5FF, 16'h0000, 1'b0);
        serial_div = 8'd1; bus_div = 8'd3;
        run_cmd(1, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1);
        run_cmd(1, 1'b0, 16'h0001, 16'h0000, 16'h0000, 1'b0);
        serial_div = 8'd0; bus_div = 8'd2;
        run_cmd(4, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0);
        run_cmd(5, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1);
        run_cmd(2, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, 1'b0);
        run_cmd(2, 1'b0, 16'h0000, 16'h0000, 16'h5A3C, 1'b0);

        // random mix
        for (int n = 0; n < 22; n++) begin
            serial_div = 8'($urandom_range(0, 2));
            bus_div    = 8'($urandom_range(0, 3));
            run_cmd(int'($urandom_range(0, 5)), 1'($urandom), 16'($urandom),
                    16'($urandom), 16'($urandom), ($urandom_range(0, 3) == 0));
        end
        finish_run();
    end
endmodule